// File: doc/BRIEF.md
# Burst Beat Address Generator

The block produces the byte address of each beat of a memory burst. A one-cycle start request brings in a start address, a burst kind, a beat size and a beat count. The generator then presents the first beat address and moves on by one beat each time the consumer strobes the advance input. A last-beat indicator is high while the final beat address is presented. A one-cycle completion pulse follows the advance strobe given on that final beat.

Three burst kinds are supported. Fixed bursts repeat the start address on every beat. Incrementing bursts add the beat size in bytes on each beat. Wrapping bursts also increment, but they stay inside an aligned window whose size is the total byte count of the burst, and they fold back to the bottom of that window when they pass its top.

The block does not move data, does not check 4 KB page crossings and does not handle unaligned start addresses.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `busy_o`, `last_o`, `done_o` and `err_o` are 0 and `addr_o` is 0.
- R2: When `start_i` is high while the block is idle and the request is legal, `addr_o` equals `start_addr_i` and `busy_o` is 1 from the next cycle onward.
- R3: Kind 2'b01 (incrementing) adds 2^`size_i` bytes to `addr_o` on each advance, so a 4-beat burst of 4-byte beats from 0x1000 gives 0x1000, 0x1004, 0x1008, 0x100C.
- R4: Kind 2'b00 (fixed) keeps `addr_o` at the start address on every beat.
- R5: Kind 2'b10 (wrapping) defines a window of (`len_i`+1)·2^`size_i` bytes whose lower bound is the start address with its low log2(window) bits cleared. The address increments, and one step past the top of the window it returns to the lower bound. A 4-beat burst of 4-byte beats from 0x1008 gives 0x1008, 0x100C, 0x1000, 0x1004.
- R6: Kind 2'b11 behaves exactly like the incrementing kind.
- R7: While busy, a cycle with `step_i` low leaves `addr_o` and `last_o` unchanged.
- R8: A burst has `len_i`+1 beats, and `last_o` is high exactly while the final beat's address is presented.
- R9: An advance on the final beat drops `busy_o` and `last_o` in the next cycle and raises `done_o` for exactly that one cycle.
- R10: A wrapping request whose `len_i` is not 1, 3, 7 or 15 sets `err_o` and starts no burst. `err_o` stays set until the next legal start, which clears it.
- R11: `start_i` while busy is ignored: the running burst's addresses continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| start_addr_i | input | ADDR_W | First beat byte address |
| burst_type_i | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 treated as incrementing |
| size_i | input | 3 | log2 of bytes per beat |
| len_i | input | LEN_W | Beat count minus one |
| step_i | input | 1 | Advance to the next beat |
| addr_o | output | ADDR_W | Current beat address |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle pulse after the final beat is advanced |
| err_o | output | 1 | Last start request was an illegal wrapping length |

## Verification
The assertions check the per-cycle rules on every cycle:
- the address holds when no advance arrives;
- the stride between consecutive beats for linear and fixed kinds;
- a wrapping step never leaves its window;
- the single-cycle completion pulse and its tie to the end of busy;
- `last_o` only while busy;
- no counter underflow;
- the error flag never coexists with a running burst.

Only the bench scenarios can show the full address sequences against independently computed values. These are the two worked examples, a 16-beat byte-wide wrap, and the reserved kind. The scenarios also show that a start request during a burst is truly ignored, and that an illegal wrapping length launches nothing and is cleared by a later legal start.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;

  typedef enum logic [1:0] {
    GS_IDLE   = 2'b00,
    GS_LINEAR = 2'b01,
    GS_WRAP   = 2'b10,
    GS_HOLD   = 2'b11
  } gen_state_e;
endpackage

// File: rtl/burst_step_calc.sv
module burst_step_calc
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  gen_state_e        mode_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [ADDR_W-1:0] inc_i,
  input  logic [ADDR_W-1:0] wrap_mask_i,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum = cur_addr_i + inc_i;
    unique case (mode_i)
      GS_LINEAR: nxt_addr_o = sum;
      GS_WRAP:   nxt_addr_o = (cur_addr_i & ~wrap_mask_i) | (sum & wrap_mask_i);
      default:   nxt_addr_o = cur_addr_i;
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    cnt_d  = load_i ? len_i : cnt_q - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> (cnt_q != '0))
    else $error("p_no_underflow_r8");
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        burst_type_i,
  input  logic [2:0]        size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  gen_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d, inc_q, inc_d, mask_q, mask_d, nxt_addr;
  logic              done_q, done_d, err_q, err_d;
  logic              accept, len_ok, launch, adv, at_last, cnt_zero, cfg_en;
  logic [2:0]        wrap_lg;
  burst_kind_e       kind;

  // Wrapping window exponent contributed by the beat count.
  always_comb begin
    len_ok  = 1'b1;
    wrap_lg = 3'd0;
    case (len_i)
      LEN_W'(1):  wrap_lg = 3'd1;
      LEN_W'(3):  wrap_lg = 3'd2;
      LEN_W'(7):  wrap_lg = 3'd3;
      LEN_W'(15): wrap_lg = 3'd4;
      default:    len_ok  = 1'b0;
    endcase
  end

  assign kind    = burst_kind_e'(burst_type_i);
  assign busy_o  = (state_q != GS_IDLE);
  assign accept  = start_i && !busy_o;
  assign launch  = accept && !(kind == BK_WRAP && !len_ok);
  assign at_last = busy_o && cnt_zero;
  assign adv     = busy_o && step_i;
  assign cfg_en  = launch;

  burst_step_calc #(.ADDR_W(ADDR_W)) u_calc (
    .mode_i      (state_q),
    .cur_addr_i  (addr_q),
    .inc_i       (inc_q),
    .wrap_mask_i (mask_q),
    .nxt_addr_o  (nxt_addr)
  );

  burst_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (launch),
    .len_i  (len_i),
    .dec_i  (adv && !at_last),
    .zero_o (cnt_zero)
  );

  // Next-state process.
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    inc_d   = ONE << size_i;
    mask_d  = (ONE << ({1'b0, size_i} + {1'b0, wrap_lg})) - ONE;
    done_d  = 1'b0;
    err_d   = err_q;
    if (accept) begin
      if (!launch) begin
        err_d = 1'b1;
      end else begin
        err_d  = 1'b0;
        addr_d = start_addr_i;
        unique case (kind)
          BK_FIXED: state_d = GS_HOLD;
          BK_WRAP:  state_d = GS_WRAP;
          default:  state_d = GS_LINEAR;
        endcase
      end
    end else if (adv) begin
      if (at_last) begin
        state_d = GS_IDLE;
        done_d  = 1'b1;
      end else begin
        addr_d = nxt_addr;
      end
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      addr_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q  <= '0;
      mask_q <= '0;
    end else if (cfg_en) begin
      inc_q  <= inc_d;
      mask_q <= mask_d;
    end
  end

  assign addr_o = addr_q;
  assign last_o = at_last;
  assign done_o = done_q;
  assign err_o  = err_q;

  p_hold_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_i) |=> ($stable(addr_o) && $stable(last_o)))
    else $error("p_hold_no_step_r7");

  p_linear_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_LINEAR && step_i && !last_o) |=> (addr_o == $past(addr_o) + inc_q))
    else $error("p_linear_stride_r3");

  p_fixed_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_HOLD && step_i && !last_o) |=> $stable(addr_o))
    else $error("p_fixed_same_r4");

  p_wrap_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_WRAP && step_i && !last_o) |=> (((addr_o ^ $past(addr_o)) & ~mask_q) == '0))
    else $error("p_wrap_window_r5");

  p_last_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> busy_o)
    else $error("p_last_busy_r8");

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("p_done_single_r9");

  p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o)
    else $error("p_done_at_end_r9");

  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o)
    else $error("p_err_idle_r10");
endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [ADDR_W-1:0] start_addr_i;
  logic [1:0]        burst_type_i;
  logic [2:0]        size_i;
  logic [LEN_W-1:0]  len_i;
  logic              step_i;
  logic [ADDR_W-1:0] addr_o;
  logic              last_o, busy_o, done_o, err_o;

  int vectors = 0;
  int fails   = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .burst_type_i(burst_type_i), .size_i(size_i), .len_i(len_i), .step_i(step_i),
    .addr_o(addr_o), .last_o(last_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] s, input logic [1:0] t,
      input int sz, input int ln, input int i);
    longint inc, total, base;
    inc = longint'(1) << sz;
    if (t == 2'b00) return s;
    if (t == 2'b10) begin
      total = inc * (ln + 1);
      base  = longint'(s) - (longint'(s) % total);
      return ADDR_W'(base + ((longint'(s) - base + i * inc) % total));
    end
    return ADDR_W'(longint'(s) + i * inc);
  endfunction

  task automatic do_start(input logic [ADDR_W-1:0] a, input logic [1:0] t, input int sz, input int ln);
    start_addr_i = a; burst_type_i = t; size_i = 3'(sz); len_i = LEN_W'(ln);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Runs a full burst, stalling one cycle at beat stall_at (negative = never).
  task automatic run_burst(input string req, input logic [ADDR_W-1:0] a, input logic [1:0] t,
      input int sz, input int ln, input int stall_at);
    logic [ADDR_W-1:0] e;
    do_start(a, t, sz, ln);
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    for (int i = 0; i <= ln; i++) begin
      e = exp_addr(a, t, sz, ln, i);
      chk(addr_o == e, req, addr_o, e);
      chk(last_o == (i == ln), "R8 last flag", last_o, (i == ln));
      if (i == stall_at) begin
        step_i = 1'b0;
        @(negedge clk);
        chk(addr_o == e, "R7 stall holds address", addr_o, e);
        chk(last_o == (i == ln), "R7 stall holds last", last_o, (i == ln));
      end
      step_i = 1'b1;
      @(negedge clk);
    end
    step_i = 1'b0;
    chk(done_o == 1'b1, "R9 done pulse", done_o, 1);
    chk(busy_o == 1'b0, "R9 busy drops", busy_o, 0);
    chk(last_o == 1'b0, "R9 last drops", last_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
  endtask

  task automatic t_reset();
    chk(busy_o == 0 && last_o == 0 && done_o == 0 && err_o == 0, "R1 reset flags",
        {busy_o, last_o, done_o, err_o}, 0);
    chk(addr_o == '0, "R1 reset address", addr_o, 0);
  endtask

  task automatic t_incr();
    run_burst("R3 incr 0x1000", 32'h1000, 2'b01, 2, 3, 1);
    run_burst("R3 incr bytes", 32'h0000_00F7, 2'b01, 0, 5, -1);
  endtask

  task automatic t_fixed();
    run_burst("R4 fixed", 32'h2000_0040, 2'b00, 2, 4, 2);
  endtask

  task automatic t_wrap();
    run_burst("R5 wrap 0x1008", 32'h1008, 2'b10, 2, 3, -1);
    run_burst("R5 wrap 16x1", 32'h0000_0A3B, 2'b10, 0, 15, 7);
    run_burst("R5 wrap 2x8", 32'h0000_0318, 2'b10, 3, 1, -1);
  endtask

  task automatic t_rsvd();
    run_burst("R6 reserved as incr", 32'h0000_0100, 2'b11, 1, 3, -1);
  endtask

  task automatic t_illegal_wrap();
    do_start(32'h4000, 2'b10, 2, 4);
    chk(err_o == 1'b1, "R10 error set", err_o, 1);
    chk(busy_o == 1'b0, "R10 no burst launched", busy_o, 0);
    @(negedge clk);
    chk(err_o == 1'b1, "R10 error held", err_o, 1);
    run_burst("R10 legal start after error", 32'h0000_0800, 2'b01, 2, 1, -1);
    chk(err_o == 1'b0, "R10 error cleared", err_o, 0);
  endtask

  task automatic t_start_busy();
    do_start(32'h0000_5000, 2'b01, 2, 2);
    step_i = 1'b1;
    @(negedge clk);
    chk(addr_o == 32'h5004, "R11 before restart", addr_o, 32'h5004);
    start_addr_i = 32'h0000_9990; burst_type_i = 2'b00; len_i = 8'd0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    step_i = 1'b0;
    chk(addr_o == 32'h5008, "R11 start ignored while busy", addr_o, 32'h5008);
    chk(last_o == 1'b1, "R11 burst length kept", last_o, 1);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    chk(done_o == 1'b1, "R11 original burst ends", done_o, 1);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; step_i = 1'b0;
    start_addr_i = '0; burst_type_i = 2'b00; size_i = 3'd0; len_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_incr();
    t_fixed();
    t_wrap();
    t_rsvd();
    t_illegal_wrap();
    t_start_busy();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule